// File: doc/BRIEF.md
# Serial Byte Repeater with Adaptive Stop Trimming

This block takes bytes handed over by an asynchronous serial receiver and sends each one again on a second serial line at the same nominal bit rate. Only a single one-byte holding register sits between the two sides. If the sender upstream runs slightly fast, bytes arrive a little more often than a full-length frame can be sent, and a holding register that fills up would sooner or later lose data.

To keep up with such a stream, the transmitter checks the holding register at the moment its stop bit finishes. If a byte is already waiting there, the stop bit of the following frame is made one sixteenth of a bit shorter. Further pressured frames shorten it again, one step each time, down to a floor of three quarters of a bit. Each frame sent with nothing waiting lengthens the stop bit again by one sixteenth.

The stop bit never drops to half a bit, so a slow receiver downstream still finds a valid high level when it samples the stop bit at its centre. A fixed mode is also available, in which every stop bit is fifteen sixteenths long. A byte that arrives while the register is still occupied is discarded, and a sticky flag records that this happened.

Top module: `uart_echo_trim`

## Requirements
- R1: After reset the serial output is high and the overrun flag is low. Whenever no frame is being sent, the output stays high.
- R2: Each frame consists of a low start bit, then 8 data bits with the least significant bit first, then a high stop bit. The start bit and every data bit last 16 ticks.
- R3: The bit timing moves forward only on cycles where the 16x tick input is high. On other cycles the serial output holds its value during a frame.
- R4: The holding register holds one byte. A byte offered in the same cycle that the transmitter takes the held byte is accepted without overrun.
- R5: A byte offered while the holding register is full, and not being emptied in that cycle, is discarded. The overrun flag is then set and stays set until reset.
- R6: In adaptive mode, if a byte is waiting when a stop bit ends, that byte's frame starts with no gap. Its stop bit is one tick shorter than the one before.
- R7: Stop-bit shortening saturates at 4 ticks, so no stop bit is shorter than 12 ticks.
- R8: Each frame that ends with the holding register empty lengthens the next stop bit by one tick, up to the full 16 ticks.
- R9: When the fixed-mode input is high, every stop bit lasts exactly 15 ticks, whatever the history of pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Oversampling tick at 16 times the bit rate |
| fixed_mode | input | 1 | 1 = constant 15/16-bit stop, 0 = adaptive stop |
| rx_valid | input | 1 | One-cycle pulse: a received byte is on rx_byte |
| rx_byte | input | 8 | Received byte |
| tx | output | 1 | Serial output, idles high |
| overrun | output | 1 | Sticky flag: a byte was discarded |

## Verification
The bench feeds a chain of bytes timed so that each one lands during the previous frame's stop bit. It then measures stop lengths of 16, 15, 14, 13, 12 and 12 ticks. A design that jumped to half a bit, or failed to saturate, would show 8 or 11. A design that forgot to shorten would keep 16.

Two more sequences check that the trim relaxes one step per unpressured frame and that fixed mode holds at 15. The bench offers one byte in the exact cycle the transmitter takes the previous one, which must not count as overrun, and then offers a third byte that must. Finally, the tick is slowed to every other cycle to confirm that bit timing follows the tick and not the clock.

// File: rtl/uart_echo_trim.sv
module uart_echo_trim #(
  parameter int DW         = 8,
  parameter int OSR        = 16,
  parameter int MAX_TRIM   = 4,
  parameter int FIXED_TRIM = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic          fixed_mode,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  output logic          tx,
  output logic          overrun
);
  localparam int SW = $clog2(OSR);
  localparam int TW = $clog2(MAX_TRIM + 1);
  localparam int BW = $clog2(DW);
  localparam logic [1:0] S_IDLE = 2'd0, S_START = 2'd1, S_DATA = 2'd2, S_STOP = 2'd3;

  logic [1:0]    st;
  logic [SW-1:0] sub;
  logic [BW-1:0] bitn;
  logic [DW-1:0] shreg, hold_data;
  logic          hold_full;
  logic [TW-1:0] trim;
  logic [SW:0]   stop_len, last;
  logic          bit_end, stop_end, take;

  assign stop_len = fixed_mode ? (SW+1)'(OSR - FIXED_TRIM)
                               : (SW+1)'(OSR) - (SW+1)'(trim);
  assign last     = (st == S_STOP) ? stop_len - (SW+1)'(1) : (SW+1)'(OSR - 1);
  assign bit_end  = tick16 && ({1'b0, sub} == last);
  assign stop_end = (st == S_STOP) && bit_end;
  assign take     = hold_full && ((st == S_IDLE) || stop_end);
  assign tx       = (st == S_START) ? 1'b0 : (st == S_DATA) ? shreg[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
      overrun   <= 1'b0;
    end else if (rx_valid) begin
      if (hold_full && !take) overrun <= 1'b1;
      else begin
        hold_full <= 1'b1;
        hold_data <= rx_byte;
      end
    end else if (take) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      sub   <= '0;
      bitn  <= '0;
      shreg <= '0;
    end else if (take) begin
      st    <= S_START;
      sub   <= '0;
      bitn  <= '0;
      shreg <= hold_data;
    end else if (tick16 && st != S_IDLE) begin
      if (bit_end) begin
        sub <= '0;
        case (st)
          S_START: st <= S_DATA;
          S_DATA: begin
            shreg <= shreg >> 1;
            bitn  <= bitn + BW'(1);
            if (bitn == BW'(DW - 1)) st <= S_STOP;
          end
          default: st <= S_IDLE;
        endcase
      end else begin
        sub <= sub + SW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) trim <= '0;
    else if (stop_end) begin
      if (hold_full && trim != TW'(MAX_TRIM)) trim <= trim + TW'(1);
      else if (!hold_full && trim != '0)      trim <= trim - TW'(1);
    end
  end
endmodule

module uart_echo_trim_chk #(
  parameter int MAX_TRIM = 4,
  parameter int TW       = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick16,
  input logic          rx_valid,
  input logic          tx,
  input logic          overrun,
  input logic          hold_full,
  input logic          take,
  input logic [1:0]    st,
  input logic [TW-1:0] trim
);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0) |-> tx);
  assert_tick_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick16 && st != 2'd0) |=> $stable(tx));
  assert_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && (!hold_full || take)) |=> hold_full);
  assert_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && hold_full && !take) |=> overrun);
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  assert_trim_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, trim} <= (TW+1)'(MAX_TRIM));
  assert_trim_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trim != $past(trim)) |-> (({1'b0, trim} == {1'b0, $past(trim)} + (TW+1)'(1)) ||
                               ({1'b0, trim} + (TW+1)'(1) == {1'b0, $past(trim)})));
endmodule

bind uart_echo_trim uart_echo_trim_chk #(.MAX_TRIM(MAX_TRIM), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_valid(rx_valid), .tx(tx),
  .overrun(overrun), .hold_full(hold_full), .take(take), .st(st), .trim(trim));

// File: tb/uart_echo_trim_bench.sv
module uart_echo_trim_bench;
  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b1, fixed_mode = 1'b0, rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic tx, overrun;
  int checks = 0, errors = 0;
  int tick_div = 1, tcnt = 0;
  bit mon_en = 0, mact = 0;
  int mcnt = 0, hc = 0, nf = 0;
  logic [7:0] mbyte;
  logic [7:0] mdat [16];
  int mstop [16];

  uart_echo_trim u_uart_echo_trim (.clk(clk), .rst_n(rst_n), .tick16(tick16),
    .fixed_mode(fixed_mode), .rx_valid(rx_valid), .rx_byte(rx_byte), .tx(tx), .overrun(overrun));

  always #4 clk = ~clk;

  always @(negedge clk) begin
    tcnt = (tcnt + 1 >= tick_div) ? 0 : tcnt + 1;
    tick16 = (tcnt == 0);
  end

  always @(negedge clk) if (mon_en) begin
    if (!mact) begin
      if (tx == 1'b0) begin mact = 1; mcnt = 0; hc = 0; end
    end else begin
      mcnt++;
      if (mcnt >= 24 && mcnt <= 136 && ((mcnt - 8) % 16) == 0) mbyte[(mcnt - 24) / 16] = tx;
      if (mcnt >= 144) begin
        if (tx) begin
          hc++;
          if (hc == 64) begin
            if (nf < 16) begin mdat[nf] = mbyte; mstop[nf] = 64; end
            nf++; mact = 0;
          end
        end else begin
          if (nf < 16) begin mdat[nf] = mbyte; mstop[nf] = hc; end
          nf++; mcnt = 0; hc = 0;
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; mon_en = 0; mact = 0; nf = 0; fixed_mode = 0; tick_div = 1;
    repeat (3) @(negedge clk);
    rst_n = 1; mon_en = 1;
  endtask

  task automatic pulse(input logic [7:0] d);
    rx_valid = 1; rx_byte = d;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic gap(input int n);
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 tx after reset", tx, 1);
    chk("R1 overrun after reset", overrun, 0);
    repeat (20) @(negedge clk);
    chk("R1 idle line high", tx, 1);
  endtask

  task automatic t_single();
    do_reset();
    pulse(8'hA5);
    repeat (260) @(negedge clk);
    chk("R2 frame count", nf, 1);
    chk("R2 data LSB first", mdat[0], 8'hA5);
    chk("R1 line returns high", tx, 1);
  endtask

  task automatic t_pressure();
    int gaps [6] = '{160, 159, 158, 157, 156, 0};
    int exp_stop [7] = '{16, 15, 14, 13, 12, 12, 64};
    do_reset();
    pulse(8'h10);
    gap(21);
    pulse(8'h11);
    for (int i = 0; i < 5; i++) begin
      gap(gaps[i]);
      pulse(8'h12 + 8'(i));
    end
    repeat (400) @(negedge clk);
    chk("R6 frame count", nf, 7);
    for (int i = 0; i < 7; i++) begin
      chk("R6 data", mdat[i], 8'h10 + 8'(i));
      chk(i < 5 ? "R6 stop shortening" : "R7 stop floor", mstop[i], exp_stop[i]);
    end
    chk("R4 no overrun in stream", overrun, 0);
    pulse(8'h20);
    repeat (300) @(negedge clk);
    pulse(8'h21);
    gap(21);
    pulse(8'h22);
    repeat (400) @(negedge clk);
    chk("R8 relax frames", nf, 10);
    chk("R8 relaxed stop", mstop[8], 14);
  endtask

  task automatic t_fixed();
    do_reset();
    fixed_mode = 1;
    pulse(8'h31);
    gap(21);
    pulse(8'h32);
    gap(159);
    pulse(8'h33);
    gap(159);
    pulse(8'h34);
    repeat (400) @(negedge clk);
    chk("R9 frame count", nf, 4);
    for (int i = 0; i < 3; i++) chk("R9 fixed stop", mstop[i], 15);
    chk("R9 data", mdat[3], 8'h34);
  endtask

  task automatic t_overrun();
    do_reset();
    pulse(8'h41);
    pulse(8'h42);
    chk("R4 same-cycle accept", overrun, 0);
    pulse(8'h43);
    chk("R5 overrun set", overrun, 1);
    repeat (450) @(negedge clk);
    chk("R5 dropped byte absent", nf, 2);
    chk("R5 first byte", mdat[0], 8'h41);
    chk("R4 second byte", mdat[1], 8'h42);
    chk("R5 overrun sticky", overrun, 1);
  endtask

  task automatic t_tick();
    int lo = 0;
    int ok;
    do_reset();
    mon_en = 0;
    tick_div = 2;
    pulse(8'h01);
    while (tx) @(negedge clk);
    while (!tx && lo < 100) begin lo++; @(negedge clk); end
    ok = (lo >= 31 && lo <= 32) ? 1 : 0;
    if (!ok) $display("FAIL R3 start length actual=%0d expected=31..32", lo);
    checks++; if (!ok) errors++;
    repeat (400) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_single();
        t_pressure();
        t_fixed();
        t_overrun();
        t_tick();
      end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule